// File: doc/BRIEF.md
# RGB-to-YCbCr Colour Matrix

This block turns a stream of pixels with three 10-bit components into three 10-bit output components through a programmable 3x3 linear transform. The transform runs in three steps. First, each input component gets its own signed input bias. Next, each output channel takes the dot product of its coefficient row with the biased inputs, then rounds and scales the result. Last, each output channel gets its own signed output bias, and the result is saturated to the 10-bit range. The reset configuration converts BT.709 RGB into limited-range YCbCr.

Software programs the transform through a 32-bit write port. Every write lands in a shadow bank. The shadow bank is copied into the active bank only on a frame-start strobe, so the transform never changes in the middle of a frame. The pixel interface carries a valid qualifier but no ready signal, so there is no back-pressure. The sink must accept a beat in every cycle where `out_valid` is high. Each output beat appears exactly three cycles after its input beat, whatever the configuration. The frame-start strobe is expected in blanking, with no beats in flight. A master enable bit chooses between converted output and an unchanged copy of the input.

Top module: `csc_matrix`

## Requirements
- R1: `out_valid` equals `in_valid` from three clock cycles earlier, and `out_pix` belongs to that same beat. Gaps in the input stream are kept in the output.
- R2: With the enable on, each output channel r is computed as clip(((sum over k of C[r][k]·(x_k + P_k)) + 512) >>> 10 + Q_r). The input components x are unsigned. P are the input biases, C are the coefficients with 1.0 = 1024, and Q are the output biases, all signed. Component 0 is `in_pix[29:20]`, component 1 is `[19:10]` and component 2 is `[9:0]`. Output channel r uses the same positions in `out_pix`.
- R3: Coefficients are 13-bit two's complement. Register 3 holds C00 in bits [28:16] and C01 in bits [12:0]. Register 4 holds C02 and C10, register 5 holds C11 and C12, and register 6 holds C20 and C21, each in the same two positions. Register 7 holds C22 in bits [28:16].
- R4: Biases are 12-bit two's complement. Register 1 holds P0 in bits [27:16] and P1 in bits [11:0]. Register 2 holds P2 in bits [11:0]. Register 8 holds Q0 and Q1 in the same positions as register 1, and register 9 holds Q2 in bits [11:0].
- R5: After reset, `out_valid` is low and the active configuration is as follows. The enable is on and all input biases are 0. The coefficient rows are (186, 627, 63), (-103, -345, 448) and (448, -407, -41). The output biases are 64, 512 and 512.
- R6: With the enable (register 0, bit 0) off, `out_pix` is the input beat unchanged, with the same three-cycle latency. The enable that applies to a beat is the one active when that beat enters.
- R7: A write alters only the shadow bank. The active bank takes a copy of the shadow bank on `frame_start`. A write issued in the same cycle as `frame_start` reaches the active bank only at the next `frame_start`.
- R8: Results below 0 come out as 0, and results above 1023 come out as 1023.
- R9: Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Copies the shadow configuration into the active bank |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word index |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input beat qualifier |
| in_pix | input | 30 | Input pixel, component 0 in the top bits |
| out_valid | output | 1 | Output beat qualifier |
| out_pix | output | 30 | Output pixel, channel 0 in the top bits |

## Verification
The bench builds the block with its default 10-bit component width, so 12-bit biases and 13-bit coefficients are in use throughout. At this width, an output bias of -2048 or +2047 and coefficients of -4096 or +4095 drive a channel past both saturation limits, and input biases of +2047 push the biased operand close to the top of its range. Random pixels, with and without gaps, are run through the reset configuration, a custom configuration with off-diagonal and negative terms, and a saturating configuration. The bench also checks that writes stay pending until the strobe and that a write issued together with the strobe is held back.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int N_CH     = 3;
  localparam int OFF_W    = 12;
  localparam int COEF_W   = 13;
  localparam int FRAC_W   = 10;
  localparam int FIELD_HI = 16;
  localparam int REG_AW   = 4;

  // word indices of the configuration registers
  localparam logic [REG_AW-1:0] REG_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] REG_PRE01 = 4'd1;
  localparam logic [REG_AW-1:0] REG_PRE2  = 4'd2;
  localparam logic [REG_AW-1:0] REG_CA    = 4'd3;
  localparam logic [REG_AW-1:0] REG_CB    = 4'd4;
  localparam logic [REG_AW-1:0] REG_CC    = 4'd5;
  localparam logic [REG_AW-1:0] REG_CD    = 4'd6;
  localparam logic [REG_AW-1:0] REG_CE    = 4'd7;
  localparam logic [REG_AW-1:0] REG_PST01 = 4'd8;
  localparam logic [REG_AW-1:0] REG_PST2  = 4'd9;

  typedef struct packed {
    logic                                en;
    logic [N_CH-1:0][OFF_W-1:0]          pre;
    logic [N_CH-1:0][OFF_W-1:0]          post;
    logic [N_CH*N_CH-1:0][COEF_W-1:0]    coef;  // index = row*N_CH + col
  } csc_cfg_t;

  function automatic csc_cfg_t csc_default();
    csc_cfg_t c;
    c.en      = 1'b1;
    c.pre     = '0;
    c.post[0] = 12'sd64;
    c.post[1] = 12'sd512;
    c.post[2] = 12'sd512;
    c.coef[0] = 13'sd186;
    c.coef[1] = 13'sd627;
    c.coef[2] = 13'sd63;
    c.coef[3] = -13'sd103;
    c.coef[4] = -13'sd345;
    c.coef[5] = 13'sd448;
    c.coef[6] = 13'sd448;
    c.coef[7] = -13'sd407;
    c.coef[8] = -13'sd41;
    return c;
  endfunction
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output csc_cfg_t          shadow,
  output csc_cfg_t          active
);
  logic [OFF_W-1:0]  off_hi, off_lo;
  logic [COEF_W-1:0] cf_hi, cf_lo;

  assign off_hi = wr_data[FIELD_HI +: OFF_W];
  assign off_lo = wr_data[0 +: OFF_W];
  assign cf_hi  = wr_data[FIELD_HI +: COEF_W];
  assign cf_lo  = wr_data[0 +: COEF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= csc_default();
      active <= csc_default();
    end else begin
      if (frame_start) active <= shadow;
      if (wr_en) begin
        case (wr_addr)
          REG_CTRL:  shadow.en <= wr_data[0];
          REG_PRE01: begin shadow.pre[0] <= off_hi; shadow.pre[1] <= off_lo; end
          REG_PRE2:  shadow.pre[2] <= off_lo;
          REG_CA:    begin shadow.coef[0] <= cf_hi; shadow.coef[1] <= cf_lo; end
          REG_CB:    begin shadow.coef[2] <= cf_hi; shadow.coef[3] <= cf_lo; end
          REG_CC:    begin shadow.coef[4] <= cf_hi; shadow.coef[5] <= cf_lo; end
          REG_CD:    begin shadow.coef[6] <= cf_hi; shadow.coef[7] <= cf_lo; end
          REG_CE:    shadow.coef[8] <= cf_hi;
          REG_PST01: begin shadow.post[0] <= off_hi; shadow.post[1] <= off_lo; end
          REG_PST2:  shadow.post[2] <= off_lo;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/csc_row.sv
module csc_row #(
  parameter int DATA_W = 10,
  parameter int X_W    = 13,
  parameter int COEF_W = 13,
  parameter int OFF_W  = 12,
  parameter int FRAC_W = 10
) (
  input  logic                     clk,
  input  logic signed [X_W-1:0]    x0,
  input  logic signed [X_W-1:0]    x1,
  input  logic signed [X_W-1:0]    x2,
  input  logic signed [COEF_W-1:0] c0,
  input  logic signed [COEF_W-1:0] c1,
  input  logic signed [COEF_W-1:0] c2,
  input  logic signed [OFF_W-1:0]  post,
  output logic [DATA_W-1:0]        y
);
  localparam int ACC_W = X_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W:0]   MAXV = (ACC_W+1)'((1 << DATA_W) - 1);

  logic signed [ACC_W-1:0] acc_q, scaled;
  logic signed [ACC_W:0]   total;

  always_ff @(posedge clk)
    acc_q <= ACC_W'(x0) * ACC_W'(c0) + ACC_W'(x1) * ACC_W'(c1) + ACC_W'(x2) * ACC_W'(c2);

  always_comb begin
    scaled = (acc_q + RND) >>> FRAC_W;
    total  = (ACC_W+1)'(scaled) + (ACC_W+1)'(post);
  end

  always_ff @(posedge clk) begin
    if (total < 0)         y <= '0;
    else if (total > MAXV) y <= '1;
    else                   y <= total[DATA_W-1:0];
  end
endmodule

// File: rtl/csc_delay.sv
module csc_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     wr_en,
  input  logic [REG_AW-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     in_valid,
  input  logic [N_CH*DATA_W-1:0]   in_pix,
  output logic                     out_valid,
  output logic [N_CH*DATA_W-1:0]   out_pix
);
  localparam int PIPE_LAT = 3;
  localparam int X_W      = ((DATA_W + 1 > OFF_W) ? DATA_W + 1 : OFF_W) + 1;
  localparam int PIX_W    = N_CH * DATA_W;

  csc_cfg_t cfg_shd, cfg_act;

  csc_regs u_regs (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shadow(cfg_shd), .active(cfg_act)
  );

  // stage 1: input bias per component
  logic signed [X_W-1:0] x_q [N_CH];
  always_ff @(posedge clk) begin
    for (int k = 0; k < N_CH; k++)
      x_q[k] <= X_W'($signed({1'b0, in_pix[(N_CH-1-k)*DATA_W +: DATA_W]}))
              + X_W'($signed(cfg_act.pre[k]));
  end

  // stages 2 and 3: one dot product per output channel
  logic [PIX_W-1:0] conv_pix;
  for (genvar r = 0; r < N_CH; r++) begin : g_row
    csc_row #(
      .DATA_W(DATA_W), .X_W(X_W), .COEF_W(COEF_W), .OFF_W(OFF_W), .FRAC_W(FRAC_W)
    ) u_row (
      .clk(clk),
      .x0(x_q[0]), .x1(x_q[1]), .x2(x_q[2]),
      .c0(cfg_act.coef[r*N_CH+0]),
      .c1(cfg_act.coef[r*N_CH+1]),
      .c2(cfg_act.coef[r*N_CH+2]),
      .post(cfg_act.post[r]),
      .y(conv_pix[(N_CH-1-r)*DATA_W +: DATA_W])
    );
  end

  // matched-latency copy of valid, enable tag and raw pixel
  logic             tag_v, tag_en;
  logic [PIX_W-1:0] byp_pix;

  csc_delay #(.W(PIX_W + 2), .DEPTH(PIPE_LAT)) u_byp (
    .clk(clk), .rst(rst),
    .din({in_valid, cfg_act.en, in_pix}),
    .dout({tag_v, tag_en, byp_pix})
  );

  assign out_valid = tag_v;
  assign out_pix   = tag_en ? conv_pix : byp_pix;
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
  import csc_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    frame_start,
  input logic                    wr_en,
  input logic [REG_AW-1:0]       wr_addr,
  input logic                    in_valid,
  input logic [N_CH*DATA_W-1:0]  in_pix,
  input logic                    out_valid,
  input logic [N_CH*DATA_W-1:0]  out_pix,
  input csc_cfg_t                act,
  input csc_cfg_t                shd
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R6
  bypass_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && out_valid && !$past(act.en, 3)) |-> (out_pix == $past(in_pix, 3)));

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act));

  // R7
  active_load_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act == $past(shd)));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > REG_PST2) |=> $stable(shd));
endmodule

bind csc_matrix csc_matrix_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .wr_en(wr_en), .wr_addr(wr_addr),
  .in_valid(in_valid), .in_pix(in_pix),
  .out_valid(out_valid), .out_pix(out_pix),
  .act(cfg_act), .shd(cfg_shd)
);

// File: tb/csc_matrix_bench.sv
module csc_matrix_bench;
  localparam int DW = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        frame_start, wr_en, in_valid;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [29:0] in_pix;
  logic        out_valid;
  logic [29:0] out_pix;

  always #10 clk = ~clk;  // 50 MHz

  csc_matrix #(.DATA_W(DW)) u_csc_matrix (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_chk = 0;
  int n_err = 0;

  // model configuration: shadow (s_) and active (a_)
  int s_pre[3], s_post[3], s_coef[9], s_en;
  int a_pre[3], a_post[3], a_coef[9], a_en;

  // expected-output pipeline
  logic        ev[3];
  logic [29:0] ed[3];
  string       et[3];

  function automatic logic [29:0] ref_pix(logic [29:0] px);
    logic [29:0] o;
    if (a_en == 0) return px;
    for (int r = 0; r < 3; r++) begin
      int sum, y;
      sum = 0;
      for (int k = 0; k < 3; k++)
        sum += a_coef[r*3+k] * (int'(px[(2-k)*10 +: 10]) + a_pre[k]);
      y = ((sum + 512) >>> 10) + a_post[r];
      if (y < 0) y = 0;
      if (y > 1023) y = 1023;
      o[(2-r)*10 +: 10] = y[9:0];
    end
    return o;
  endfunction

  task automatic step(input logic v, input logic [29:0] px, input logic fs,
                      input logic we, input logic [3:0] wa, input logic [31:0] wd,
                      input string tag);
    n_chk++;
    if (out_valid !== ev[2]) begin
      n_err++;
      $display("FAIL %s out_valid: actual %0b expected %0b", et[2], out_valid, ev[2]);
    end else if (ev[2]) begin
      n_chk++;
      if (out_pix !== ed[2]) begin
        n_err++;
        $display("FAIL %s out_pix: actual %0d/%0d/%0d expected %0d/%0d/%0d", et[2],
                 out_pix[29:20], out_pix[19:10], out_pix[9:0],
                 ed[2][29:20], ed[2][19:10], ed[2][9:0]);
      end
    end
    ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
    ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
    ev[0] = v;     ed[0] = ref_pix(px); et[0] = tag;
    in_valid = v; in_pix = px; frame_start = fs;
    wr_en = we; wr_addr = wa; wr_data = wd;
    if (fs) begin
      a_pre = s_pre; a_post = s_post; a_coef = s_coef; a_en = s_en;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic strobe();
    idle(4, "R7");
    step(1'b0, '0, 1'b1, 1'b0, '0, '0, "R7");
  endtask

  function automatic logic [31:0] p12(int a, int b);
    return (32'(a & 'hfff) << 16) | 32'(b & 'hfff);
  endfunction

  function automatic logic [31:0] p13(int a, int b);
    return (32'(a & 'h1fff) << 16) | 32'(b & 'h1fff);
  endfunction

  // R3 R4: pack the shadow model into register words
  task automatic push_cfg();
    step(0, '0, 0, 1, 4'd0, 32'(s_en & 1), "R4");
    step(0, '0, 0, 1, 4'd1, p12(s_pre[0], s_pre[1]), "R4");
    step(0, '0, 0, 1, 4'd2, p12(0, s_pre[2]), "R4");
    step(0, '0, 0, 1, 4'd3, p13(s_coef[0], s_coef[1]), "R3");
    step(0, '0, 0, 1, 4'd4, p13(s_coef[2], s_coef[3]), "R3");
    step(0, '0, 0, 1, 4'd5, p13(s_coef[4], s_coef[5]), "R3");
    step(0, '0, 0, 1, 4'd6, p13(s_coef[6], s_coef[7]), "R3");
    step(0, '0, 0, 1, 4'd7, p13(s_coef[8], 0), "R3");
    step(0, '0, 0, 1, 4'd8, p12(s_post[0], s_post[1]), "R4");
    step(0, '0, 0, 1, 4'd9, p12(0, s_post[2]), "R4");
  endtask

  task automatic stream(input int n, input int gap_pct, input string tag);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = ($urandom_range(99) >= gap_pct);
      step(v, 30'($urandom), 1'b0, 1'b0, '0, '0, tag);
    end
  endtask

  task automatic pix(input int c0, input int c1, input int c2, input string tag);
    step(1'b1, {10'(c0), 10'(c1), 10'(c2)}, 1'b0, 1'b0, '0, '0, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = '0; et[i] = "R1"; end
    // R5 reset configuration in the model
    s_en = 1; s_pre = '{0, 0, 0}; s_post = '{64, 512, 512};
    s_coef = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
    a_pre = s_pre; a_post = s_post; a_coef = s_coef; a_en = s_en;

    rst = 1'b1; frame_start = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    in_valid = 0; in_pix = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_err++;
        $display("FAIL R5 out_valid in reset: actual %0b expected 0", out_valid);
      end
    end
    rst = 1'b0;

    // R5 R2: reset configuration, fixed colours then random with gaps (R1)
    pix(0, 0, 0, "R5");
    pix(1023, 1023, 1023, "R5");
    pix(1023, 0, 0, "R5");
    pix(0, 1023, 0, "R5");
    pix(0, 0, 1023, "R5");
    idle(2, "R1");
    pix(512, 512, 512, "R2");
    stream(40, 0, "R2");
    stream(40, 40, "R1");

    // R7: new configuration pending, output still uses the old one
    s_coef = '{1024, 300, -200, -512, 2047, 17, 0, -1, 900};
    s_pre  = '{-100, 50, 2047};
    s_post = '{-30, 7, -2048};
    push_cfg();
    stream(20, 10, "R7");
    strobe();
    // R2 R3 R4: custom configuration in effect
    stream(40, 20, "R3");
    pix(0, 0, 0, "R4");
    pix(1023, 1023, 1023, "R4");

    // R8: saturation at both ends
    s_coef = '{4095, 4095, 4095, -4096, -4096, -4096, 0, 0, 0};
    s_pre  = '{0, 0, 0};
    s_post = '{0, 0, 2047};
    push_cfg();
    strobe();
    pix(1023, 1023, 1023, "R8");
    pix(0, 0, 0, "R8");
    pix(1, 0, 0, "R8");
    stream(20, 0, "R8");
    s_post = '{-2048, 2047, -2048};
    s_coef = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
    push_cfg();
    strobe();
    stream(10, 0, "R8");

    // R6: bypass with the same latency, back-to-back beats
    s_en = 0;
    push_cfg();
    strobe();
    stream(30, 0, "R6");
    stream(20, 50, "R6");

    // R7: write together with the strobe is held back
    s_en = 1;
    push_cfg();
    idle(4, "R7");
    step(1'b0, '0, 1'b1, 1'b1, 4'd0, 32'd0, "R7");
    s_en = 0;                   // shadow now off, active on
    stream(15, 0, "R7");
    strobe();
    stream(15, 0, "R7");

    // R9: unmapped writes do not disturb the configuration
    s_en = 1;
    s_pre = '{0, 0, 0}; s_post = '{64, 512, 512};
    s_coef = '{186, 627, 63, -103, -345, 448, 448, -407, -41};
    push_cfg();
    for (int a = 10; a < 16; a++) step(0, '0, 0, 1, 4'(a), 32'hffff_ffff, "R9");
    strobe();
    stream(20, 0, "R9");
    step(0, '0, 1, 1, 4'd13, 32'h1234_5678, "R9");
    stream(20, 0, "R9");
    idle(4, "R1");

    summary();
    $finish;
  end
endmodule